// File: doc/BRIEF.md
# Per-Channel Control and Status Register Bank

This block is the register bank of a three-channel data formatter. A bus master reaches it through a plain command interface. Each cycle the master presents a command (idle, write or read), a byte address and a 32-bit write word. Read results come back on a registered 32-bit read bus. Each channel has one read-write control word and one read-only status word.

The control word sets the channel's enable, its arbitration priority and its packet length. The bank drives these settings to the datapath as separate outputs, with the packet length already turned into a word count. The status word shows the channel's FIFO free space. The bank samples that count from an input port every cycle, so a read returns a recent value without any extra traffic.

Every cycle the command is decoded into one of three named access kinds. ACC_NONE covers idle and the reserved command code. ACC_WR applies a write to the addressed control word, if there is one. ACC_RD loads the read register from the address decode. No state is kept between accesses beyond the registers themselves.

Top module: `chan_csr_bank`

## Requirements
- R1: While rst_n is low at a rising clock edge, every register takes its default: channel enable 1, priority 3, length code 0 (decoded length 4), status count 0x20, and read data 0. A read of address 0x10 issued in the first cycle after reset returns 0x20.
- R2: The control words of channels 0, 1 and 2 are at byte addresses 0x00, 0x04 and 0x08. The status words of channels 0, 1 and 2 are at 0x10, 0x14 and 0x18.
- R3: In a control word, bit 0 is the enable, bits [2:1] are the priority and bits [5:3] are the length code. A write followed by a read returns the written value AND 0x3F, so bits [31:6] always read 0. After the write, ch_en and ch_prio show the new fields.
- R4: ch_len carries 6 bits per channel and decodes the length code as follows: 1 gives 8, 2 gives 16 and 3 gives 32. Codes 0 and 4 to 7 give 4.
- R5: Bits [7:0] of a status word hold the channel's fifo_free value, sampled at every clock edge. Bits [31:8] read 0. A write to a status address leaves its contents unchanged.
- R6: The command encoding is 2'b00 idle, 2'b01 write, 2'b10 read and 2'b11 reserved. Idle and reserved change no register and leave rdata unchanged.
- R7: rdata takes the addressed word at the clock edge that samples a read command. It holds that value until the next read.
- R8: A read of any address other than those in R2 returns 0. A write to such an address changes no register.
- R9: Reset is synchronous and active low. One cycle of reset during operation restores all defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Bus command: 00 idle, 01 write, 10 read, 11 reserved |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Registered read word |
| fifo_free | input | 24 | FIFO free-space counts, 8 bits per channel, channel 0 in the low bits |
| ch_en | output | 3 | Per-channel enable |
| ch_prio | output | 6 | Per-channel priority, 2 bits each |
| ch_len | output | 18 | Per-channel decoded packet length in words, 6 bits each |

## Verification
A read result appears on rdata at the edge that samples the read command. The monitor therefore compares it at the falling edge that follows, and it pops the expected word that the driver queued when it issued that read. Control outputs change at the edge that samples a write and are checked half a cycle later. A status word trails fifo_free by one edge, so the bench changes a count at least one full cycle before reading it. Checks that something has no effect use these same windows: rdata must still hold its value after idle or reserved commands, and read-backs must be unchanged after writes to status or unmapped addresses.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_RSVD  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WR,
        ACC_RD
    } acc_e;

    // Writable control fields; enable sits at bit 0.
    typedef struct packed {
        logic [2:0] len_code;
        logic [1:0] prio;
        logic       en;
    } ctrl_fields_t;

    localparam int CTRL_W = $bits(ctrl_fields_t);
    localparam int LEN_W  = 6;

    function automatic logic [LEN_W-1:0] len_decode(input logic [2:0] code);
        logic [LEN_W-1:0] words;
        unique case (code)
            3'd1:    words = LEN_W'(8);
            3'd2:    words = LEN_W'(16);
            3'd3:    words = LEN_W'(32);
            default: words = LEN_W'(4);
        endcase
        return words;
    endfunction

endpackage

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
    import csr_bank_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  ctrl_fields_t wr_val,
    output ctrl_fields_t q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.en       <= 1'b1;
            q.prio     <= 2'd3;
            q.len_code <= 3'd0;
        end else if (wr_en) begin
            q <= wr_val;
        end
    end

endmodule

// File: rtl/csr_stat_reg.sv
module csr_stat_reg #(
    parameter int              FREE_W  = 8,
    parameter logic [FREE_W-1:0] RST_VAL = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_in,
    output logic [FREE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= free_in;
    end

endmodule

// File: rtl/chan_csr_bank.sv
module chan_csr_bank
    import csr_bank_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int FREE_W    = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int STAT_BASE = 'h10,
    parameter int STRIDE    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cmd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH*FREE_W-1:0] fifo_free,
    output logic [NUM_CH-1:0]        ch_en,
    output logic [NUM_CH*2-1:0]      ch_prio,
    output logic [NUM_CH*LEN_W-1:0]  ch_len
);

    localparam logic [FREE_W-1:0] STAT_RST = FREE_W'(8'h20);

    acc_e               acc;
    logic [NUM_CH-1:0]  ctrl_hit;
    logic [NUM_CH-1:0]  stat_hit;
    ctrl_fields_t       ctrl_q [NUM_CH];
    logic [FREE_W-1:0]  stat_q [NUM_CH];
    logic [DATA_W-1:0]  rd_word;
    ctrl_fields_t       wr_fields;
    logic               unused_wdata_hi;

    assign wr_fields       = ctrl_fields_t'(wdata[CTRL_W-1:0]);
    assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

    // Access decode: the reserved code behaves like idle.
    always_comb begin
        unique case (bus_cmd_e'(cmd))
            CMD_WRITE: acc = ACC_WR;
            CMD_READ:  acc = ACC_RD;
            default:   acc = ACC_NONE;
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_BASE + i*STRIDE);
        localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + i*STRIDE);

        assign ctrl_hit[i] = (addr == CTRL_ADDR);
        assign stat_hit[i] = (addr == STAT_ADDR);

        csr_ctrl_reg u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  ((acc == ACC_WR) && ctrl_hit[i]),
            .wr_val (wr_fields),
            .q      (ctrl_q[i])
        );

        csr_stat_reg #(
            .FREE_W  (FREE_W),
            .RST_VAL (STAT_RST)
        ) u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .free_in (fifo_free[i*FREE_W +: FREE_W]),
            .q       (stat_q[i])
        );

        assign ch_en[i]                 = ctrl_q[i].en;
        assign ch_prio[i*2 +: 2]        = ctrl_q[i].prio;
        assign ch_len[i*LEN_W +: LEN_W] = len_decode(ctrl_q[i].len_code);
    end

    // Read-back mux; unmapped addresses fall through to zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctrl_hit[i]) rd_word[CTRL_W-1:0] = ctrl_q[i];
            if (stat_hit[i]) rd_word[FREE_W-1:0] = stat_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              rdata <= '0;
        else if (acc == ACC_RD)  rdata <= rd_word;
    end

endmodule

// File: rtl/chan_csr_bank_chk.sv
module chan_csr_bank_chk
    import csr_bank_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int FREE_W    = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int STAT_BASE = 'h10,
    parameter int STRIDE    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              cmd,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [DATA_W-1:0]       rdata,
    input logic [NUM_CH-1:0]       ch_en,
    input logic [NUM_CH*2-1:0]     ch_prio,
    input logic [NUM_CH*LEN_W-1:0] ch_len
);

    logic was_rst = 1'b0;
    logic mapped;
    logic unused_chk;

    assign unused_chk = ^wdata[DATA_W-1:3];

    always_ff @(posedge clk) was_rst <= !rst_n;

    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(addr) == CTRL_BASE + i*STRIDE) mapped = 1'b1;
            if (int'(addr) == STAT_BASE + i*STRIDE) mapped = 1'b1;
        end
    end

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        (was_rst && rst_n) |-> (&ch_en) && (&ch_prio) && (rdata == '0)); // R1

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:FREE_W] == '0); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDLE || cmd == CMD_RSVD) |=>
            $stable(rdata) && $stable(ch_en) && $stable(ch_prio) && $stable(ch_len)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && !mapped) |=> rdata == '0); // R8

    AST_READ_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) |=> $stable(ch_en) && $stable(ch_prio) && $stable(ch_len)); // R7

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ca
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_BASE + i*STRIDE);

        AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_WRITE && addr == CA) |=>
                ch_en[i] == $past(wdata[0]) && ch_prio[i*2 +: 2] == $past(wdata[2:1])); // R3

        AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(ch_len[i*LEN_W +: LEN_W]) == 1 && ch_len[i*LEN_W +: 2] == 2'b00); // R4
    end

endmodule

bind chan_csr_bank chan_csr_bank_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREE_W(FREE_W),
    .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE), .STRIDE(STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_en(ch_en), .ch_prio(ch_prio), .ch_len(ch_len)
);

// File: tb/chan_csr_bank_test.sv
`timescale 1ns/1ps
module chan_csr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [23:0] fifo_free = 24'h202020;
    logic [2:0]  ch_en;
    logic [5:0]  ch_prio;
    logic [17:0] ch_len;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_fire = 1'b0;
    logic [31:0] last_rd = '0;

    logic [5:0]  ctrl_m [3];
    logic [7:0]  free_m [3];

    always #5 clk = ~clk;

    chan_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fifo_free(fifo_free), .ch_en(ch_en),
        .ch_prio(ch_prio), .ch_len(ch_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] len_of(input logic [2:0] c);
        case (c)
            3'd1: return 6'd8;
            3'd2: return 6'd16;
            3'd3: return 6'd32;
            default: return 6'd4;
        endcase
    endfunction

    function automatic logic [31:0] model_word(input logic [7:0] a);
        for (int i = 0; i < 3; i++) begin
            if (a == 8'(4*i))        return {26'd0, ctrl_m[i]};
            if (a == 8'(8'h10+4*i))  return {24'd0, free_m[i]};
        end
        return 32'd0;
    endfunction

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_fire <= rst_n && (cmd == 2'b10);
    always @(negedge clk) begin
        if (rd_fire) begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
            last_rd = rdata;
        end
    end

    task automatic idle_cycle();
        @(negedge clk);
        cmd = 2'b00;
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        cmd  = 2'b10;
        addr = a;
        exp_q.push_back(model_word(a));
        tag_q.push_back(req);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cmd   = 2'b01;
        addr  = a;
        wdata = d;
        for (int i = 0; i < 3; i++)
            if (a == 8'(4*i)) ctrl_m[i] = d[5:0];
    endtask

    task automatic set_free(input int ch, input logic [7:0] v);
        @(negedge clk);
        cmd = 2'b00;
        fifo_free[ch*8 +: 8] = v;
        free_m[ch] = v;
        @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            ctrl_m[i] = 6'b000_11_1;
            free_m[i] = 8'h20;
        end
    endtask

    task automatic check_outputs(input string req);
        for (int i = 0; i < 3; i++) begin
            check(req, {31'd0, ch_en[i]}, {31'd0, ctrl_m[i][0]});
            check(req, {30'd0, ch_prio[i*2 +: 2]}, {30'd0, ctrl_m[i][2:1]});
            check(req, {26'd0, ch_len[i*6 +: 6]}, {26'd0, len_of(ctrl_m[i][5:3])});
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check_outputs("R1 reset outputs");
        check("R1 rdata reset", rdata, 32'd0);
        // R1: read of status in first cycle after reset sees 0x20
        rst_n = 1'b1;
        cmd   = 2'b10;
        addr  = 8'h10;
        exp_q.push_back(32'h20);
        tag_q.push_back("R1 status default");
        fifo_free = 24'h202020;
        idle_cycle();
        idle_cycle();

        // R2: control defaults at each mapped control address
        bus_read(8'h00, "R2 ctrl0 default");
        bus_read(8'h04, "R2 ctrl1 default");
        bus_read(8'h08, "R2 ctrl2 default");
        idle_cycle();

        // R3, R4: program each channel and read back
        bus_write(8'h00, 32'h0000_0009);
        bus_write(8'h04, 32'h0000_0013);
        bus_write(8'h08, 32'h0000_001D);
        idle_cycle();
        check_outputs("R3 R4 programmed outputs");
        bus_read(8'h00, "R3 ctrl0 readback");
        bus_read(8'h04, "R3 ctrl1 readback");
        bus_read(8'h08, "R3 ctrl2 readback");

        // R3: reserved bits masked; R4: code 4 and code 7 decode to 4
        bus_write(8'h04, 32'hFFFF_FFE2);
        bus_write(8'h08, 32'h0000_0038);
        idle_cycle();
        check_outputs("R4 out-of-range codes");
        bus_read(8'h04, "R3 reserved bits masked");
        bus_read(8'h08, "R3 ctrl2 code7 readback");
        idle_cycle();

        // R5: status mirrors fifo_free, write ignored
        set_free(0, 8'h05);
        set_free(1, 8'hAB);
        set_free(2, 8'hFF);
        bus_read(8'h10, "R5 status0");
        bus_read(8'h14, "R5 status1");
        bus_read(8'h18, "R5 status2");
        bus_write(8'h14, 32'h1234_5678);
        bus_read(8'h14, "R5 status write ignored");
        idle_cycle();

        // R6, R7: idle and reserved commands change nothing, rdata holds
        bus_read(8'h00, "R7 read before idle");
        @(negedge clk);
        cmd = 2'b00; addr = 8'h00; wdata = 32'h0;
        @(negedge clk);
        cmd = 2'b11; addr = 8'h04; wdata = 32'h3F;
        @(negedge clk);
        cmd = 2'b00;
        @(negedge clk);
        check("R6 R7 rdata holds after idle/reserved", rdata, last_rd);
        check_outputs("R6 outputs unchanged");
        bus_read(8'h04, "R6 ctrl1 unchanged by reserved cmd");

        // R8: unmapped reads return zero, unmapped writes no effect
        bus_read(8'h0C, "R8 unmapped 0x0C");
        bus_read(8'h1C, "R8 unmapped 0x1C");
        bus_read(8'h02, "R8 unaligned 0x02");
        bus_write(8'h0C, 32'h0000_003F);
        bus_write(8'h01, 32'h0000_003F);
        idle_cycle();
        check_outputs("R8 outputs after unmapped writes");
        bus_read(8'h00, "R8 ctrl0 intact");
        bus_read(8'h04, "R8 ctrl1 intact");
        idle_cycle();
        idle_cycle();

        // R9: one cycle of reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        cmd   = 2'b00;
        fifo_free = 24'h202020;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_outputs("R9 defaults after reset pulse");
        check("R9 rdata cleared", rdata, 32'd0);
        bus_read(8'h08, "R9 ctrl2 default");
        idle_cycle();
        idle_cycle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule